// File: doc/BRIEF.md
# Two-Port Word Memory with Collision Busy Flags

This block is a synchronous memory shared by two independent ports, called left and right. Each port has its own active-low select, a read/write line (high reads, low writes), an active-low output enable, an address and byte-wide data in and out. Both ports can reach every word in the same cycle. Reads are registered: the word appears on the port's data output one clock after the request, qualified by a drive-enable flag that stands in for a tri-state pin. Two ports may read one word together freely.

When both ports select the same word in one cycle and at least one of them writes, a three-state arbiter picks a winner. The port that already held that address in the previous cycle wins. If both or neither did, the left port wins. The loser sees its active-low busy flag fall and its write is dropped for as long as the collision lasts. A mode input chooses between master and slave operation. In master mode the block arbitrates itself and drives busy. In slave mode the arbiter stays idle and each port's write is gated by a busy line fed from an outside master, so several devices can be stacked side by side for wider words.

Arbiter states: `ARB_IDLE` (no collision owner), `ARB_LEFT_HOLDS` (left owns the collided word), `ARB_RIGHT_HOLDS` (right owns it). Transitions: `ARB_IDLE` to `ARB_LEFT_HOLDS` when a collision starts and left wins. `ARB_IDLE` to `ARB_RIGHT_HOLDS` when a collision starts and only right held the address one cycle earlier. Either holding state stays put while the collision persists and returns to `ARB_IDLE` in the first cycle without one. Reset and slave mode force `ARB_IDLE`.

Top module: `dpr_busy_ram`

## Requirements
- R1: With select low, read/write low and the port's busy high, the port's data input is stored at its address on the clock edge.
- R2: With select low, read/write high and output enable low, the addressed word appears on the port's data output after the next edge, with its drive-enable flag high.
- R3: If output enable is high or select is high, the drive-enable flag is low after the next edge and the data output reads zero.
- R4: Both ports reading the same word in one cycle each receive it, and neither busy flag falls.
- R5: In master mode a collision (both selected, equal addresses, at least one writing) pulls exactly one busy flag low in that same cycle; both flags are never low together.
- R6: At the start of a collision, the port that was selected on that same address in the previous cycle wins; if both or neither were, left wins.
- R7: The winner keeps ownership on every following cycle while the collision persists, even when the tie-break rule of R6 would pick the other port.
- R8: A losing port's write is dropped; a read in the same cycle as a write to its word returns the value held before that write.
- R9: In slave mode no local arbitration happens. Each busy output repeats that port's external busy input, and an external busy low blocks that port's write.
- R10: In master mode the external busy inputs have no effect: with no collision, both busy outputs stay high and writes go through.
- R11: After reset both drive-enable flags and data outputs are zero, both busy flags are high and the arbiter is idle.
- R12: In slave mode, when both ports write one word in the same cycle with busy high, the left port's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_master | input | 1 | 1 = master (local arbitration), 0 = slave |
| l_ce_n | input | 1 | Left select, active low |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | AW | Left word address |
| l_din | input | DW | Left write data |
| l_dout | output | DW | Left registered read data |
| l_dout_en | output | 1 | Left read data is being driven |
| l_busy_n | output | 1 | Left busy flag, active low, always driven |
| l_busy_in_n | input | 1 | Left busy from an external master (slave mode) |
| r_ce_n | input | 1 | Right select, active low |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | AW | Right word address |
| r_din | input | DW | Right write data |
| r_dout | output | DW | Right registered read data |
| r_dout_en | output | 1 | Right read data is being driven |
| r_busy_n | output | 1 | Right busy flag, active low, always driven |
| r_busy_in_n | input | 1 | Right busy from an external master (slave mode) |

## Verification
The properties assume that every control and address input is settled before each rising edge and that the mode input changes only between cycles, never while a collision is being held. They also assume the external busy inputs matter only in slave mode. The stimulus changes inputs only on falling edges and keeps the addresses within a 16-word window, so collisions, ties and held ownership come up often. It preloads that window before any read, so every expected read value is defined. It switches modes only between whole traffic segments.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    typedef enum logic [1:0] {
        ARB_IDLE        = 2'd0,
        ARB_LEFT_HOLDS  = 2'd1,
        ARB_RIGHT_HOLDS = 2'd2
    } arb_state_t;
endpackage

// File: rtl/dpr_port_ctl.sv
// Decodes one port's control lines into select, write and read strobes.
module dpr_port_ctl (
    input  logic ce_n,
    input  logic rw,
    input  logic oe_n,
    input  logic busy_n,
    output logic sel,
    output logic wr_req,
    output logic wr_go,
    output logic rd_go
);
    always_comb begin
        sel    = !ce_n;
        wr_req = !ce_n && !rw;
        wr_go  = wr_req && busy_n;
        rd_go  = !ce_n && rw && !oe_n;
    end
endmodule

// File: rtl/dpr_arbiter.sv
// Same-word collision arbiter: earlier selection wins, left on a tie.
module dpr_arbiter
    import dpr_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master,
    input  logic          sel_l,
    input  logic          sel_r,
    input  logic          wr_l,
    input  logic          wr_r,
    input  logic [AW-1:0] addr_l,
    input  logic [AW-1:0] addr_r,
    output logic          lose_l,
    output logic          lose_r
);
    arb_state_t    state_q, state_d;
    logic          held_l_q, held_r_q;
    logic [AW-1:0] addr_l_q, addr_r_q;
    logic          clash, early_l, early_r, right_first;

    always_comb begin
        clash       = master && sel_l && sel_r && (addr_l == addr_r) && (wr_l || wr_r);
        early_l     = held_l_q && (addr_l_q == addr_l);
        early_r     = held_r_q && (addr_r_q == addr_r);
        right_first = early_r && !early_l;
    end

    // history of each port's selection for first-come ordering
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_l_q <= 1'b0;
            held_r_q <= 1'b0;
            addr_l_q <= '0;
            addr_r_q <= '0;
        end else begin
            held_l_q <= sel_l;
            held_r_q <= sel_r;
            addr_l_q <= addr_l;
            addr_r_q <= addr_r;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (clash) state_d = right_first ? ARB_RIGHT_HOLDS : ARB_LEFT_HOLDS;
            end
            ARB_LEFT_HOLDS: begin
                if (!clash) state_d = ARB_IDLE;
            end
            ARB_RIGHT_HOLDS: begin
                if (!clash) state_d = ARB_IDLE;
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        lose_l = 1'b0;
        lose_r = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                lose_l = clash && right_first;
                lose_r = clash && !right_first;
            end
            ARB_LEFT_HOLDS:  lose_r = clash;
            ARB_RIGHT_HOLDS: lose_l = clash;
            default: ;
        endcase
    end
endmodule

// File: rtl/dpr_mem_core.sv
// Word array with two write ports and two registered read ports.
module dpr_mem_core #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_l,
    input  logic          rd_l,
    input  logic [AW-1:0] addr_l,
    input  logic [DW-1:0] din_l,
    output logic [DW-1:0] dout_l,
    output logic          den_l,
    input  logic          we_r,
    input  logic          rd_r,
    input  logic [AW-1:0] addr_r,
    input  logic [DW-1:0] din_r,
    output logic [DW-1:0] dout_r,
    output logic          den_r
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // right first, left last: left data survives a same-word double write
    always_ff @(posedge clk) begin
        if (we_r) mem[addr_r] <= din_r;
        if (we_l) mem[addr_l] <= din_l;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_l <= '0;
            den_l  <= 1'b0;
            dout_r <= '0;
            den_r  <= 1'b0;
        end else begin
            dout_l <= rd_l ? mem[addr_l] : '0;
            den_l  <= rd_l;
            dout_r <= rd_r ? mem[addr_r] : '0;
            den_r  <= rd_r;
        end
    end
endmodule

// File: rtl/dpr_busy_ram.sv
// Two-port memory with same-word collision busy flags and master/slave mode.
module dpr_busy_ram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ms_master,
    input  logic          l_ce_n,
    input  logic          l_rw,
    input  logic          l_oe_n,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_din,
    output logic [DW-1:0] l_dout,
    output logic          l_dout_en,
    output logic          l_busy_n,
    input  logic          l_busy_in_n,
    input  logic          r_ce_n,
    input  logic          r_rw,
    input  logic          r_oe_n,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_din,
    output logic [DW-1:0] r_dout,
    output logic          r_dout_en,
    output logic          r_busy_n,
    input  logic          r_busy_in_n
);
    logic l_sel, l_wreq, l_wgo, l_rgo;
    logic r_sel, r_wreq, r_wgo, r_rgo;
    logic lose_l, lose_r;

    dpr_port_ctl u_lctl (
        .ce_n(l_ce_n), .rw(l_rw), .oe_n(l_oe_n), .busy_n(l_busy_n),
        .sel(l_sel), .wr_req(l_wreq), .wr_go(l_wgo), .rd_go(l_rgo)
    );

    dpr_port_ctl u_rctl (
        .ce_n(r_ce_n), .rw(r_rw), .oe_n(r_oe_n), .busy_n(r_busy_n),
        .sel(r_sel), .wr_req(r_wreq), .wr_go(r_wgo), .rd_go(r_rgo)
    );

    dpr_arbiter #(.AW(AW)) u_arb (
        .clk(clk), .rst_n(rst_n), .master(ms_master),
        .sel_l(l_sel), .sel_r(r_sel), .wr_l(l_wreq), .wr_r(r_wreq),
        .addr_l(l_addr), .addr_r(r_addr),
        .lose_l(lose_l), .lose_r(lose_r)
    );

    // master: local verdict; slave: pass the external flag through
    always_comb begin
        l_busy_n = ms_master ? !lose_l : l_busy_in_n;
        r_busy_n = ms_master ? !lose_r : r_busy_in_n;
    end

    dpr_mem_core #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .we_l(l_wgo), .rd_l(l_rgo), .addr_l(l_addr), .din_l(l_din),
        .dout_l(l_dout), .den_l(l_dout_en),
        .we_r(r_wgo), .rd_r(r_rgo), .addr_r(r_addr), .din_r(r_din),
        .dout_r(r_dout), .den_r(r_dout_en)
    );
endmodule

// File: rtl/dpr_busy_ram_chk.sv
module dpr_busy_ram_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ms_master,
    input logic          l_ce_n,
    input logic          l_rw,
    input logic          l_oe_n,
    input logic [AW-1:0] l_addr,
    input logic          l_dout_en,
    input logic          l_busy_n,
    input logic          l_busy_in_n,
    input logic          r_ce_n,
    input logic          r_rw,
    input logic          r_oe_n,
    input logic [AW-1:0] r_addr,
    input logic          r_dout_en,
    input logic          r_busy_n,
    input logic          r_busy_in_n
);
    assert_busy_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ms_master |-> (l_busy_n || r_busy_n));

    assert_left_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_ce_n && l_rw && !l_oe_n) |=> l_dout_en);

    assert_right_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_ce_n && r_rw && !r_oe_n) |=> r_dout_en);

    assert_left_output_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (l_oe_n || l_ce_n) |=> !l_dout_en);

    assert_right_output_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_oe_n || r_ce_n) |=> !r_dout_en);

    assert_dual_read_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_master && !l_ce_n && !r_ce_n && l_rw && r_rw) |-> (l_busy_n && r_busy_n));

    assert_ext_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_master && (l_ce_n || r_ce_n || (l_addr != r_addr))) |-> (l_busy_n && r_busy_n));

    assert_slave_echo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_master |-> ((l_busy_n == l_busy_in_n) && (r_busy_n == r_busy_in_n)));
endmodule

bind dpr_busy_ram dpr_busy_ram_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_dpr_busy_ram.sv
`timescale 1ns/1ps
module test_dpr_busy_ram;
    localparam int AW = 11;
    localparam int DW = 8;

    typedef struct {
        logic          en_l;
        logic [DW-1:0] d_l;
        logic          en_r;
        logic [DW-1:0] d_r;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_master = 1'b1;
    logic l_ce_n = 1'b1, l_rw = 1'b1, l_oe_n = 1'b1, l_busy_in_n = 1'b1;
    logic r_ce_n = 1'b1, r_rw = 1'b1, r_oe_n = 1'b1, r_busy_in_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_din = '0, r_din = '0;
    logic [DW-1:0] l_dout, r_dout;
    logic l_dout_en, r_dout_en, l_busy_n, r_busy_n;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    exp_t q[$];
    logic [DW-1:0] ref_mem [16];
    bit p_sel_l = 0, p_sel_r = 0;
    logic [AW-1:0] p_addr_l = '0, p_addr_r = '0;
    int owner = 0;

    always #5 clk = ~clk;

    dpr_busy_ram #(.AW(AW), .DW(DW)) i_dpr_busy_ram (.*);

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // driver: one cycle of two-port traffic, expectations from the requirements
    task automatic step(input bit m,
                        input bit cl, input bit rl, input bit ol, input logic [AW-1:0] al,
                        input logic [DW-1:0] dl, input bit bl_in,
                        input bit cr, input bit rr, input bit orr, input logic [AW-1:0] ar,
                        input logic [DW-1:0] dr, input bit br_in,
                        input string tag);
        bit sel_l, sel_r, wr_l, wr_r, clash, e_l, e_r, bl, br;
        int win;
        exp_t it;
        @(negedge clk);
        ms_master = m;
        l_ce_n = cl; l_rw = rl; l_oe_n = ol; l_addr = al; l_din = dl; l_busy_in_n = bl_in;
        r_ce_n = cr; r_rw = rr; r_oe_n = orr; r_addr = ar; r_din = dr; r_busy_in_n = br_in;
        #1;
        sel_l = !cl; sel_r = !cr;
        wr_l = sel_l && !rl; wr_r = sel_r && !rr;
        clash = m && sel_l && sel_r && (al == ar) && (wr_l || wr_r);
        e_l = p_sel_l && (p_addr_l == al);
        e_r = p_sel_r && (p_addr_r == ar);
        win = 0;
        if (clash) win = (owner != 0) ? owner : ((e_r && !e_l) ? 2 : 1);
        if (m) begin
            bl = !(clash && win == 2);
            br = !(clash && win == 1);
        end else begin
            bl = bl_in;
            br = br_in;
        end
        chk(l_busy_n === bl, tag, "left busy", int'(l_busy_n), int'(bl));
        chk(r_busy_n === br, tag, "right busy", int'(r_busy_n), int'(br));
        it.en_l = sel_l && rl && !ol;
        it.d_l  = it.en_l ? ref_mem[al[3:0]] : '0;
        it.en_r = sel_r && rr && !orr;
        it.d_r  = it.en_r ? ref_mem[ar[3:0]] : '0;
        it.tag  = tag;
        q.push_back(it);
        if (wr_r && br) ref_mem[ar[3:0]] = dr;
        if (wr_l && bl) ref_mem[al[3:0]] = dl;
        p_sel_l = sel_l; p_sel_r = sel_r; p_addr_l = al; p_addr_r = ar;
        owner = win;
    endtask

    task automatic idle();
        step(1'b1, 1, 1, 1, '0, '0, 1, 1, 1, 1, '0, '0, 1, "R3");
    endtask

    // monitor: compare registered read results one edge after each request
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(l_dout_en === e.en_l, e.tag, "left drive enable", int'(l_dout_en), int'(e.en_l));
                chk(l_dout === e.d_l, e.tag, "left read data", int'(l_dout), int'(e.d_l));
                chk(r_dout_en === e.en_r, e.tag, "right drive enable", int'(r_dout_en), int'(e.en_r));
                chk(r_dout === e.d_r, e.tag, "right read data", int'(r_dout), int'(e.d_r));
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk(l_dout_en === 1'b0 && l_dout === '0, "R11", "left out in reset", int'(l_dout_en), 0);
        chk(r_dout_en === 1'b0 && r_dout === '0, "R11", "right out in reset", int'(r_dout_en), 0);
        chk(l_busy_n === 1'b1 && r_busy_n === 1'b1, "R11", "busy in reset", int'(l_busy_n & r_busy_n), 1);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: preload the 16-word window, alternating ports
        for (int i = 0; i < 16; i++) begin
            if (i % 2 == 0) step(1, 0, 0, 1, AW'(i), DW'(i * 7 + 3), 1, 1, 1, 1, '0, '0, 1, "R1");
            else            step(1, 1, 1, 1, '0, '0, 1, 0, 0, 1, AW'(i), DW'(i * 7 + 3), 1, "R1");
        end
        idle();
        // R2 / R4: both ports read word 5 together
        step(1, 0, 1, 0, 11'd5, '0, 1, 0, 1, 0, 11'd5, '0, 1, "R4");
        // R2: different words
        step(1, 0, 1, 0, 11'd2, '0, 1, 0, 1, 0, 11'd3, '0, 1, "R2");
        // R3: output enable high on left, select high on right
        step(1, 0, 1, 1, 11'd2, '0, 1, 1, 1, 0, 11'd3, '0, 1, "R3");
        idle();
        // R6: tie write collision on word 3, left wins
        step(1, 0, 0, 1, 11'd3, 8'hA1, 1, 0, 0, 1, 11'd3, 8'hB2, 1, "R6");
        idle();
        step(1, 0, 1, 0, 11'd3, '0, 1, 1, 1, 1, '0, '0, 1, "R8");
        idle();
        // R6: right selects word 9 first, then left writes it and loses
        step(1, 1, 1, 1, '0, '0, 1, 0, 1, 0, 11'd9, '0, 1, "R6");
        step(1, 0, 0, 1, 11'd9, 8'h55, 1, 0, 1, 0, 11'd9, '0, 1, "R6");
        // R7: both now held the word, ownership stays with right
        step(1, 0, 0, 1, 11'd9, 8'h66, 1, 0, 1, 0, 11'd9, '0, 1, "R7");
        idle();
        // R8: blocked writes left word 9 unchanged
        step(1, 0, 1, 0, 11'd9, '0, 1, 1, 1, 1, '0, '0, 1, "R8");
        // R8: read-before-write on word 4 from different ports, right held it first
        step(1, 1, 1, 1, '0, '0, 1, 0, 0, 1, 11'd4, 8'h77, 1, "R8");
        step(1, 0, 1, 0, 11'd4, '0, 1, 0, 0, 1, 11'd4, 8'h78, 1, "R8");
        idle();
        // R10: external busy ignored in master mode
        step(1, 0, 0, 1, 11'd6, 8'h61, 0, 0, 0, 1, 11'd7, 8'h71, 0, "R10");
        step(1, 0, 1, 0, 11'd6, '0, 0, 0, 1, 0, 11'd7, '0, 0, "R10");
        // R9: slave mode, left write blocked by external busy, busy echoed
        step(0, 0, 0, 1, 11'd8, 8'hEE, 0, 1, 1, 1, '0, '0, 1, "R9");
        step(0, 0, 1, 0, 11'd8, '0, 1, 1, 1, 1, '0, '0, 0, "R9");
        // R12: slave double write to word 10 keeps left data
        step(0, 0, 0, 1, 11'd10, 8'h3C, 1, 0, 0, 1, 11'd10, 8'hC3, 1, "R12");
        step(0, 1, 1, 1, '0, '0, 1, 0, 1, 0, 11'd10, '0, 1, "R12");
        step(1, 1, 1, 1, '0, '0, 1, 1, 1, 1, '0, '0, 1, "R3");

        // random traffic in segments of fixed mode
        for (int seg = 0; seg < 6; seg++) begin
            bit m;
            m = (seg % 3) != 2;
            for (int n = 0; n < 500; n++) begin
                step(m,
                     ($urandom % 4) == 0, $urandom % 2, ($urandom % 5) == 0, AW'($urandom % 16),
                     DW'($urandom), ($urandom % 4) != 0,
                     ($urandom % 4) == 0, $urandom % 2, ($urandom % 5) == 0, AW'($urandom % 16),
                     DW'($urandom), ($urandom % 4) != 0,
                     m ? "R5" : "R9");
            end
            idle();
        end
        idle();
        @(posedge clk);
        #3;
        @(posedge clk);
        #3;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule